// File: doc/BRIEF.md
# Fail-on-First Vector Length Truncator

This block settles the effective vector length of a vector operation that runs with fail-on-first enabled. A request carries a requested length, a test mode, a condition-bit selector and a failure polarity. The block then walks the elements from index 0 upward, one per clock. It presents the index of the element it is examining on `elem_idx`. The surrounding logic answers in the same cycle with that element's 4-bit condition field and its fault flag. The scan stops at the first element that fails, or after the last element. The block then reports the resulting length, a trap request and an all-nop indication together with a one-cycle `done` strobe.

The block has two test modes. In condition mode, one bit of each element's condition field is tested. The truncated length may be zero, and in that case every vector operation that follows must act as a no-operation. In load/store mode, each element's fault flag is tested. A fault beyond element 0 truncates the length. A fault on element 0 never produces a zero length: it raises a trap request and leaves the length untouched.

The controller has three states. IDLE waits for a request. On an accepted request it moves to SCAN, or straight to FINISH when the clamped length is zero. SCAN stays put while the current element passes and is not the last one. It moves to FINISH on a failing element or after the last element. FINISH raises `done` for one cycle and always returns to IDLE.

Top module: `ffirst_vl_trunc`

## Requirements
- R1: After reset, `in_ready` is 1 and `done`, `trap`, `all_nop` and `out_vl` are all 0.
- R2: A request is taken only when `in_valid` and `in_ready` are both high, and `in_ready` is high only in IDLE. While a scan is running, `in_ready` is 0, and any request presented on the inputs has no effect on the result that is being produced.
- R3: In condition mode (`req_mode`=0), `req_sel` picks bit 0..3 of `elem_cr`. With `req_fail_set`=1 an element fails when that bit is 1; with `req_fail_set`=0 it fails when that bit is 0.
- R4: In condition mode, if the first failing element has index i, then `out_vl` is i. This includes i = 0, which gives `out_vl` = 0. `trap` is 0 in this mode.
- R5: In load/store mode (`req_mode`=1), an element fails when `elem_fault` is 1. If the first fault is at index i > 0, then `out_vl` is i and `trap` is 0.
- R6: In load/store mode, a fault on element 0 sets `trap` to 1. `out_vl` then keeps the (clamped) requested length and `all_nop` stays 0.
- R7: If no examined element fails, `out_vl` equals the clamped requested length.
- R8: At `done`, `all_nop` is 1 exactly when `out_vl` is 0 and `trap` is 0.
- R9: The block examines one element per clock. If a request is accepted at clock edge k, element j is sampled at edge k+1+j. `done` is high for exactly one cycle, after the edge that samples the deciding element, or after edge k itself when the length is zero.
- R10: A requested length above 64 is treated as 64. A requested length of 0 examines no element and ends with `out_vl`=0 and `all_nop`=1.
- R11: During SCAN, `elem_idx` shows the index of the element being examined. The index starts at 0 and rises by one per cycle.
- R12: `out_vl`, `trap` and `all_nop` change only at the edge that enters FINISH, and they hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request (IDLE) |
| req_vl | input | 7 | Requested vector length, 0..127, clamped to 64 |
| req_mode | input | 1 | 0 = condition-bit test, 1 = load/store fault test |
| req_sel | input | 2 | Condition bit selected for the test |
| req_fail_set | input | 1 | 1 = a set bit fails, 0 = a clear bit fails |
| elem_idx | output | 6 | Index of the element under test |
| elem_cr | input | 4 | Condition field of element `elem_idx` |
| elem_fault | input | 1 | Fault flag of element `elem_idx` |
| done | output | 1 | One-cycle completion strobe |
| out_vl | output | 7 | Resulting vector length |
| trap | output | 1 | First-element load/store fault, trap requested |
| all_nop | output | 1 | Resulting length is zero; following vector operations do nothing |

## Verification
The bench targets a failure on element 0 in each mode. A design that mixes up the two modes would either return zero in load/store mode without trapping, or raise a trap in condition mode. The bench also drives a length of zero, a length above 64 and a full scan of 64 passing elements. An off-by-one in the last-element compare or in the clamp would show up as a length of 63 or 65, or as a scan that stops too late. Both polarities and all four bit selects are exercised, so a design that inverts the test or selects the wrong bit stops at the wrong index. The bench also counts the cycles to `done` and presents requests while a scan is running, so it catches a design that skips elements, stalls, or restarts on a request it should not accept.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } ffvl_state_e;

    typedef enum logic {
        MODE_CR   = 1'b0,
        MODE_LDST = 1'b1
    } ffvl_mode_e;

endpackage

// File: rtl/ffvl_elem_test.sv
module ffvl_elem_test
    import ffvl_pkg::*;
#(
    parameter int CR_W  = 4,
    localparam int SEL_W = $clog2(CR_W)
) (
    input  ffvl_mode_e       mode,
    input  logic [SEL_W-1:0] sel,
    input  logic             fail_set,
    input  logic [CR_W-1:0]  cr,
    input  logic             fault,
    output logic             fail
);

    logic [CR_W-1:0] bit_fails;

    for (genvar b = 0; b < CR_W; b++) begin : g_bit
        assign bit_fails[b] = (cr[b] == fail_set);
    end

    always_comb begin
        unique case (mode)
            MODE_CR:   fail = bit_fails[sel];
            MODE_LDST: fail = fault;
            default:   fail = 1'b0;
        endcase
    end

endmodule

// File: rtl/ffvl_idx_ctr.sv
module ffvl_idx_ctr #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (clear)   idx <= '0;
        else if (advance) idx <= idx + 1'b1;
    end

    assign at_last = (idx == last_idx);

    AST_ADV_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !at_last);                                   // R11
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (idx == $past(idx) + 1'b1));     // R11

endmodule

// File: rtl/ffirst_vl_trunc.sv
module ffirst_vl_trunc
    import ffvl_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int CR_W   = 4,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int SEL_W = $clog2(CR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VL_W-1:0]  req_vl,
    input  logic             req_mode,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             req_fail_set,
    output logic [IDX_W-1:0] elem_idx,
    input  logic [CR_W-1:0]  elem_cr,
    input  logic             elem_fault,
    output logic             done,
    output logic [VL_W-1:0]  out_vl,
    output logic             trap,
    output logic             all_nop
);

    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    ffvl_state_e      state_q, state_d;
    ffvl_mode_e       mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             pol_q;
    logic [VL_W-1:0]  vl_q;
    logic [IDX_W-1:0] last_q;

    logic [VL_W-1:0]  vl_clamp;
    logic [VL_W-1:0]  vl_less1;
    logic             accept;
    logic             elem_fail;
    logic             at_last;
    logic             ctr_advance;
    logic [IDX_W-1:0] idx;

    assign vl_clamp = (req_vl > VL_CAP) ? VL_CAP : req_vl;
    assign vl_less1 = vl_clamp - 1'b1;
    assign accept   = in_valid && in_ready;

    ffvl_elem_test #(.CR_W(CR_W)) i_test (
        .mode     (mode_q),
        .sel      (sel_q),
        .fail_set (pol_q),
        .cr       (elem_cr),
        .fault    (elem_fault),
        .fail     (elem_fail)
    );

    assign ctr_advance = (state_q == ST_SCAN) && !elem_fail && !at_last;

    ffvl_idx_ctr #(.MAX_VL(MAX_VL)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .advance  (ctr_advance),
        .last_idx (last_q),
        .idx      (idx),
        .at_last  (at_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = (vl_clamp == '0) ? ST_FINISH : ST_SCAN;
            ST_SCAN:   if (elem_fail || at_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CR;
            sel_q  <= '0;
            pol_q  <= 1'b0;
            vl_q   <= '0;
            last_q <= '0;
        end else if (accept) begin
            mode_q <= ffvl_mode_e'(req_mode);
            sel_q  <= req_sel;
            pol_q  <= req_fail_set;
            vl_q   <= vl_clamp;
            last_q <= vl_less1[IDX_W-1:0];
        end
    end

    // Result registers, loaded only on entry to FINISH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vl  <= '0;
            trap    <= 1'b0;
            all_nop <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid && vl_clamp == '0) begin
                    out_vl  <= '0;
                    trap    <= 1'b0;
                    all_nop <= 1'b1;
                end
                ST_SCAN: if (elem_fail) begin
                    if (mode_q == MODE_LDST && idx == '0) begin
                        out_vl  <= vl_q;
                        trap    <= 1'b1;
                        all_nop <= 1'b0;
                    end else begin
                        out_vl  <= VL_W'(idx);
                        trap    <= 1'b0;
                        all_nop <= (idx == '0);
                    end
                end else if (at_last) begin
                    out_vl  <= vl_q;
                    trap    <= 1'b0;
                    all_nop <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready = (state_q == ST_IDLE);
        done     = (state_q == ST_FINISH);
        elem_idx = idx;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R9
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);                                              // R2
    AST_LDST_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_LDST && vl_q != '0) |-> (out_vl != '0)); // R6
    AST_TRAP_LDST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap) |-> (mode_q == MODE_LDST && out_vl == vl_q));     // R6
    AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_vl <= vl_q));                                      // R4
    AST_NOP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_nop) |-> (!trap && out_vl == '0));                  // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d != ST_FINISH) |=> ($stable(out_vl) && $stable(trap)));  // R12

endmodule

// File: tb/test_ffirst_vl_trunc.sv
module test_ffirst_vl_trunc;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [6:0] req_vl;
    logic       req_mode;
    logic [1:0] req_sel;
    logic       req_fail_set;
    logic [5:0] elem_idx;
    logic [3:0] elem_cr;
    logic       elem_fault;
    logic       done;
    logic [6:0] out_vl;
    logic       trap;
    logic       all_nop;

    logic [3:0] cr_mem  [64];
    logic       flt_mem [64];

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign elem_cr    = cr_mem[elem_idx];
    assign elem_fault = flt_mem[elem_idx];

    ffirst_vl_trunc i_ffirst_vl_trunc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .req_vl(req_vl), .req_mode(req_mode), .req_sel(req_sel),
        .req_fail_set(req_fail_set), .elem_idx(elem_idx), .elem_cr(elem_cr),
        .elem_fault(elem_fault), .done(done), .out_vl(out_vl), .trap(trap),
        .all_nop(all_nop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic void model(input int req, input bit mode, input int sel, input bit pol,
                                  output int vl, output bit trp, output int cyc);
        int n;
        n   = (req > 64) ? 64 : req;
        vl  = n;
        trp = 1'b0;
        cyc = n + 1;
        if (n == 0) begin
            cyc = 1;
            return;
        end
        for (int i = 0; i < n; i++) begin
            bit f;
            f = mode ? flt_mem[i] : (cr_mem[i][sel] == pol);
            if (f) begin
                if (mode && i == 0) trp = 1'b1;
                else                vl  = i;
                cyc = i + 2;
                return;
            end
        end
    endfunction

    task automatic fill_pass(input int sel, input bit pol);
        for (int i = 0; i < 64; i++) begin
            logic [3:0] v;
            v         = 4'($urandom);
            v[sel]    = ~pol;
            cr_mem[i] = v;
            flt_mem[i] = 1'b0;
        end
    endtask

    task automatic run(input int req, input bit mode, input int sel, input bit pol,
                       input bit noisy, input string tag);
        int  e_vl, e_cyc, cyc, vl0;
        bit  e_trp, idx_bad, rdy_bad;
        model(req, mode, sel, pol, e_vl, e_trp, e_cyc);
        @(negedge clk);
        in_valid = 1'b1; req_vl = 7'(req); req_mode = mode;
        req_sel = 2'(sel); req_fail_set = pol;
        chk(in_ready === 1'b1, {"R2 ready in idle ", tag}, int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        if (noisy) begin
            req_vl = 7'd1; req_mode = ~mode; req_fail_set = ~pol;
        end else begin
            in_valid = 1'b0;
        end
        cyc = 1; idx_bad = 0; rdy_bad = 0;
        while (!done && cyc < 200) begin
            if (elem_idx != 6'(cyc - 1)) idx_bad = 1;
            if (in_ready) rdy_bad = 1;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        chk(cyc == e_cyc, {"R9 cycles to done ", tag}, cyc, e_cyc);
        chk(int'(out_vl) == e_vl, {"R4/R5/R7/R10 out_vl ", tag}, int'(out_vl), e_vl);
        chk(trap == e_trp, {"R6 trap ", tag}, int'(trap), int'(e_trp));
        chk(all_nop == (e_vl == 0 && !e_trp), {"R8 all_nop ", tag},
            int'(all_nop), int'(e_vl == 0 && !e_trp));
        chk(!idx_bad, {"R11 elem_idx sequence ", tag}, int'(idx_bad), 0);
        chk(!rdy_bad, {"R2 in_ready low while busy ", tag}, int'(rdy_bad), 0);
        vl0 = int'(out_vl);
        @(negedge clk);
        chk(!done && int'(out_vl) == vl0, {"R12 result held, done single ", tag},
            int'(out_vl), vl0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20201220);
        rst_n = 1'b0; in_valid = 1'b0; req_vl = '0; req_mode = 1'b0;
        req_sel = '0; req_fail_set = 1'b0;
        fill_pass(0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready && !done && !trap && !all_nop && out_vl == 0, "R1 reset state",
            {in_ready, done, trap, all_nop, |out_vl}, 5'b10000);

        // R3/R4: condition mode, first element fails -> zero
        fill_pass(2, 1'b1); cr_mem[0][2] = 1'b1;
        run(20, 1'b0, 2, 1'b1, 1'b0, "cr elem0 fail");
        // R7: full 64 passing
        fill_pass(1, 1'b0);
        run(64, 1'b0, 1, 1'b0, 1'b0, "cr full 64");
        // R3 polarity clear-fails, R4 index 3
        fill_pass(0, 1'b0); cr_mem[3][0] = 1'b0;
        run(10, 1'b0, 0, 1'b0, 1'b0, "cr pol0 idx3");
        // R5: load/store fault at 5
        fill_pass(0, 1'b0); flt_mem[5] = 1'b1;
        run(30, 1'b1, 0, 1'b0, 1'b0, "ldst idx5");
        // R6: load/store fault on element 0
        fill_pass(0, 1'b0); flt_mem[0] = 1'b1;
        run(12, 1'b1, 0, 1'b0, 1'b0, "ldst elem0 trap");
        // R10: above-range length clamps
        fill_pass(3, 1'b1);
        run(100, 1'b0, 3, 1'b1, 1'b0, "clamp 100");
        // R10: zero length
        run(0, 1'b1, 0, 1'b0, 1'b0, "zero length");
        // R7: fault beyond requested length ignored
        fill_pass(0, 1'b0); flt_mem[8] = 1'b1;
        run(8, 1'b1, 0, 1'b0, 1'b0, "fault past end");
        // R2: requests during scan ignored
        fill_pass(1, 1'b1); cr_mem[17][1] = 1'b1;
        run(40, 1'b0, 1, 1'b1, 1'b1, "busy requests ignored");

        // Random runs: mostly passing elements so failures land across the vector
        for (int r = 0; r < 60; r++) begin
            int  req, sel;
            bit  mode, pol;
            req  = $urandom_range(0, 70);
            mode = 1'($urandom);
            sel  = $urandom_range(0, 3);
            pol  = 1'($urandom);
            for (int i = 0; i < 64; i++) begin
                logic [3:0] v;
                v = 4'($urandom);
                if ($urandom_range(0, 19) != 0) v[sel] = ~pol;
                cr_mem[i]  = v;
                flt_mem[i] = ($urandom_range(0, 19) == 0);
            end
            run(req, mode, sel, pol, 1'($urandom), $sformatf("random %0d", r));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule